// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks which resident frame to give up when a new page has to be brought in. It keeps a valid flag and a referenced flag for each of a fixed number of frames, and a hand pointer that survives from one request to the next. Every access to a frame sets its referenced flag through a touch port. Nothing else is recorded per access, and no timestamps are kept. An install port marks a frame as occupied and writes its referenced flag.

A victim request gets an answer in one of two ways. If any frame is empty, the empty frame with the lowest index is returned in the request cycle and the hand does not move. Otherwise the hand sweeps forward around the circle. A frame whose referenced flag is set has the flag cleared and is passed over. The first frame whose flag is clear becomes the victim, and the hand is then left one place past it. A one-cycle done pulse returns the victim index. If a touch and a sweep clear meet on the same frame in the same cycle, the touch wins.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, every frame is empty with its referenced flag clear, the hand is at frame 0, and both `victim_done` and `busy` are low.
- R2: When a request is accepted while at least one frame is empty, `victim_done` rises right after the accepting edge (latency 0). It carries the lowest-indexed empty frame, and the hand does not move.
- R3: When every frame is occupied, the sweep starts at the hand. At each step of the sweep, a frame whose referenced flag is set gets the flag cleared and is skipped. The first frame whose flag is clear is returned. Latency is the number of frames examined.
- R4: After a sweep picks a victim, the hand stands at the victim index plus one. It wraps from frame N-1 to frame 0.
- R5: A touch sets the referenced flag of `touch_idx` from the next edge on.
- R6: If a touch and a sweep clear hit the same frame in the same cycle, the flag ends up set.
- R7: An install marks `inst_idx` occupied and sets its referenced flag to `inst_ref`.
- R8: If every frame is occupied and referenced, the sweep clears all N flags and returns the frame where it started. `victim_done` rises at the (N+1)th edge after the accepting edge.
- R9: `victim_done` stays high for exactly one cycle. While `busy` is high, a request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| touch_valid | input | 1 | Access to a frame in this cycle |
| touch_idx | input | IW | Frame that was accessed |
| inst_valid | input | 1 | Install a page into a frame |
| inst_idx | input | IW | Frame being installed |
| inst_ref | input | 1 | Referenced flag value written on install |
| victim_req | input | 1 | Ask for a victim; accepted only while not busy |
| busy | output | 1 | A sweep is in progress |
| victim_done | output | 1 | One-cycle pulse: victim index is valid |
| victim_idx | output | IW | Chosen frame |

## Verification
The latency bound in R8 holds only for sweeps during which no touch or install arrives. The checker therefore tracks disturbed sweeps and checks the bound only on sweeps that no touch or install reached. The stimulus presents at most one touch or install per cycle and never raises both at once. Each indexed frame is in range by construction of the index width. The single sweep that carries a concurrent touch, the R6 case, is arranged so that the latency bound is not relied on during it.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic [0:0] {
    CV_IDLE  = 1'b0,
    CV_SWEEP = 1'b1
  } cv_state_e;
endpackage

// File: rtl/cvs_frame_bits.sv
module cvs_frame_bits #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic          inst_en,
  input  logic [IW-1:0] inst_idx,
  input  logic          inst_ref,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  valid_q,
  output logic [N-1:0]  ref_q
);

  // One slot per frame; a touch beats a clear, an install writes its own flag
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic hit_touch, hit_inst, hit_clr;
    assign hit_touch = touch_en && (touch_idx == IW'(g));
    assign hit_inst  = inst_en  && (inst_idx  == IW'(g));
    assign hit_clr   = clr_en   && (clr_idx   == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
        ref_q[g]   <= 1'b0;
      end else if (hit_inst) begin
        valid_q[g] <= 1'b1;
        ref_q[g]   <= inst_ref | hit_touch;
      end else if (hit_touch) begin
        ref_q[g]   <= 1'b1;
      end else if (hit_clr) begin
        ref_q[g]   <= 1'b0;
      end
    end
  end

  // R5 / R6: a touch always leaves the flag set, even against a clear
  p_touch_sets_r5: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> ref_q[$past(touch_idx)]);

  // R7: install makes the frame occupied
  p_inst_valid_r7: assert property (@(posedge clk) disable iff (rst)
    inst_en |=> valid_q[$past(inst_idx)]);

  // R3: an uncontested clear drops the flag
  p_clear_drops_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(touch_en && touch_idx == clr_idx) && !(inst_en && inst_idx == clr_idx))
      |=> !ref_q[$past(clr_idx)]);

endmodule

// File: rtl/cvs_empty_pick.sv
module cvs_empty_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  valid_q,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Lowest-indexed empty frame wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/cvs_sweep_fsm.sv
module cvs_sweep_fsm
  import cvs_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          empty_found,
  input  logic [IW-1:0] empty_idx,
  input  logic [N-1:0]  valid_q,
  input  logic [N-1:0]  ref_q,
  input  logic          touch_en,
  input  logic          inst_en,
  output logic          clr_en,
  output logic [IW-1:0] clr_idx,
  output logic          busy,
  output logic          done_q,
  output logic [IW-1:0] victim_q
);

  localparam int CW = $clog2(N + 2);

  cv_state_e     state_q;
  logic [IW-1:0] hand_q;
  logic [IW-1:0] hand_nxt;
  logic          here_valid, here_ref, take_here;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] v);
    return (v == IW'(N - 1)) ? '0 : v + 1'b1;
  endfunction

  assign hand_nxt   = step(hand_q);
  assign here_valid = valid_q[hand_q];
  assign here_ref   = ref_q[hand_q];
  assign take_here  = !here_valid || !here_ref;
  assign clr_en     = (state_q == CV_SWEEP) && !take_here;
  assign clr_idx    = hand_q;
  assign busy       = (state_q == CV_SWEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= CV_IDLE;
      hand_q   <= '0;
      done_q   <= 1'b0;
      victim_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        CV_IDLE: begin
          if (req) begin
            if (empty_found) begin
              done_q   <= 1'b1;
              victim_q <= empty_idx;
            end else begin
              state_q <= CV_SWEEP;
            end
          end
        end
        CV_SWEEP: begin
          hand_q <= hand_nxt;
          if (take_here) begin
            done_q   <= 1'b1;
            victim_q <= hand_q;
            state_q  <= CV_IDLE;
          end
        end
        default: state_q <= CV_IDLE;
      endcase
    end
  end

  // Checker state: sweep length and whether anything touched the flags meanwhile
  logic [CW-1:0] sweep_cnt;
  logic          disturbed;
  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_cnt <= '0;
      disturbed <= 1'b0;
    end else if (state_q != CV_SWEEP) begin
      sweep_cnt <= '0;
      disturbed <= 1'b0;
    end else begin
      sweep_cnt <= sweep_cnt + 1'b1;
      disturbed <= disturbed | touch_en | inst_en;
    end
  end

  // R8: an undisturbed sweep decides by its (N+1)th examined edge
  p_sweep_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == CV_SWEEP && !disturbed) |-> (sweep_cnt <= CW'(N)));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R4: a sweep victim leaves the hand one past it
  p_hand_after_r4: assert property (@(posedge clk) disable iff (rst)
    (done_q && $past(state_q) == CV_SWEEP) |-> (hand_q == step(victim_q)));

  // R2: an empty-frame answer leaves the hand where it was
  p_empty_keeps_hand_r2: assert property (@(posedge clk) disable iff (rst)
    (done_q && $past(state_q) == CV_IDLE) |-> $stable(hand_q));

  // R9: a request while busy does not restart anything
  p_busy_ignores_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == CV_SWEEP && !take_here) |=> (state_q == CV_SWEEP));

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_valid,
  input  logic [IW-1:0] touch_idx,
  input  logic          inst_valid,
  input  logic [IW-1:0] inst_idx,
  input  logic          inst_ref,
  input  logic          victim_req,
  output logic          busy,
  output logic          victim_done,
  output logic [IW-1:0] victim_idx
);

  logic [N-1:0]  valid_q, ref_q;
  logic          clr_en;
  logic [IW-1:0] clr_idx;
  logic          empty_found;
  logic [IW-1:0] empty_idx;

  cvs_frame_bits #(.N(N), .IW(IW)) u_bits (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (touch_valid),
    .touch_idx (touch_idx),
    .inst_en   (inst_valid),
    .inst_idx  (inst_idx),
    .inst_ref  (inst_ref),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .valid_q   (valid_q),
    .ref_q     (ref_q)
  );

  cvs_empty_pick #(.N(N), .IW(IW)) u_pick (
    .valid_q (valid_q),
    .found   (empty_found),
    .idx     (empty_idx)
  );

  cvs_sweep_fsm #(.N(N), .IW(IW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req         (victim_req),
    .empty_found (empty_found),
    .empty_idx   (empty_idx),
    .valid_q     (valid_q),
    .ref_q       (ref_q),
    .touch_en    (touch_valid),
    .inst_en     (inst_valid),
    .clr_en      (clr_en),
    .clr_idx     (clr_idx),
    .busy        (busy),
    .done_q      (victim_done),
    .victim_q    (victim_idx)
  );

  // R1: quiet outputs straight after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!victim_done && !busy));

endmodule

// File: tb/sim_clock_victim_sel.sv
module sim_clock_victim_sel;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          touch_valid = 1'b0;
  logic [IW-1:0] touch_idx = '0;
  logic          inst_valid = 1'b0;
  logic [IW-1:0] inst_idx = '0;
  logic          inst_ref = 1'b0;
  logic          victim_req = 1'b0;
  logic          busy, victim_done;
  logic [IW-1:0] victim_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  clock_victim_sel #(.N(N)) u0 (
    .clk(clk), .rst(rst),
    .touch_valid(touch_valid), .touch_idx(touch_idx),
    .inst_valid(inst_valid), .inst_idx(inst_idx), .inst_ref(inst_ref),
    .victim_req(victim_req), .busy(busy),
    .victim_done(victim_done), .victim_idx(victim_idx)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic install(input int idx, input bit r);
    inst_valid = 1'b1; inst_idx = IW'(idx); inst_ref = r;
    @(negedge clk);
    inst_valid = 1'b0;
  endtask

  task automatic touch(input int idx);
    touch_valid = 1'b1; touch_idx = IW'(idx);
    @(negedge clk);
    touch_valid = 1'b0;
  endtask

  // touch_at / stray_at: edge number after the accepting edge (0 = none)
  task automatic run_req(input string tag, input int exp_idx, input int exp_lat,
                         input int touch_at, input int t_idx, input int stray_at);
    int lat = -1;
    int got_idx = -1;
    int extra = 0;
    victim_req = 1'b1;
    @(negedge clk);
    victim_req = 1'b0;
    for (int k = 0; k < 40 && lat < 0; k++) begin
      if (victim_done) begin
        lat = k; got_idx = int'(victim_idx);
      end else begin
        touch_valid = (k + 1 == touch_at);
        touch_idx   = IW'(t_idx);
        victim_req  = (k + 1 == stray_at);
        @(negedge clk);
      end
    end
    touch_valid = 1'b0;
    victim_req  = 1'b0;
    check({tag, " victim"}, got_idx, exp_idx);
    check({tag, " latency"}, lat, exp_lat);
    @(negedge clk);
    check({tag, " R9 pulse width"}, int'(victim_done), 0);
    for (int k = 0; k < 3; k++) begin
      if (victim_done || busy) extra++;
      @(negedge clk);
    end
    check({tag, " R9 no extra activity"}, extra, 0);
  endtask

  task automatic t_reset;
    check("R1 done low", int'(victim_done), 0);
    check("R1 busy low", int'(busy), 0);
    run_req("R1 all empty", 0, 0, 0, 0, 0);
  endtask

  task automatic t_empty_first;
    for (int i = 0; i < 4; i++) install(i, 1'b1);
    run_req("R2 lowest empty", 4, 0, 0, 0, 0);
  endtask

  task automatic t_sweep_basic;
    install(4, 1'b1); install(5, 1'b0); install(6, 1'b1); install(7, 1'b1);
    // hand at 0 (R2 kept it): clears 0..4, picks 5
    run_req("R3 first unreferenced", 5, 6, 0, 0, 0);
  endtask

  task automatic t_wrap;
    // hand 6: clears 6,7, wraps to 0
    run_req("R4 wrap past last", 0, 3, 0, 0, 0);
    run_req("R4 hand one past victim", 1, 1, 0, 0, 0);
  endtask

  task automatic t_touch;
    touch(2);
    run_req("R5 touched frame skipped", 3, 2, 0, 0, 0);
  endtask

  task automatic t_full_rev;
    for (int i = 0; i < N; i++) touch(i);
    // hand 4, every flag set; stray request mid-sweep must be ignored (R9)
    run_req("R8 full revolution", 4, N + 1, 0, 0, 3);
  endtask

  task automatic t_set_wins;
    touch(5); touch(6);
    // hand 5: edge1 clears 5, edge2 clears 6 while touch on 6 lands
    run_req("R6 setup sweep", 7, 3, 2, 6, 0);
    for (int i = 0; i < 6; i++) touch(i);
    // hand 0: clears 0..5, frame 6 still set => cleared, picks 7
    run_req("R6 touch beat clear", 7, 8, 0, 0, 0);
  endtask

  task automatic t_install_ref;
    touch(0);
    install(0, 1'b0);
    run_req("R7 install writes ref 0", 0, 1, 0, 0, 0);
    install(1, 1'b1);
    run_req("R7 install writes ref 1", 2, 2, 0, 0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_empty_first();
    t_sweep_basic();
    t_wrap();
    t_touch();
    t_full_rev();
    t_set_wins();
    t_install_ref();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule